// File: doc/BRIEF.md
# SPI Word Transmitter with Start/Busy Control Register

This block puts one 16-bit word onto a write-only SPI link under the control of a single 32-bit register. The host writes the payload into the low half of the register, with an enable bit and a start bit in the bits just above it. It then polls the start bit, which stays high while the word is being shifted out and is cleared by the hardware when the word has gone.

A start only acts when the enable bit is set in the same write and no transfer is in flight. The serial clock runs at the system clock divided by the parameter `DIV`, which must be at least 2. Each serial clock period is low for its first `DIV/2` system cycles and high for the rest. Data leaves MSB first in SPI mode 0: the clock idles low, the data line changes on the falling edge and is stable across the rising edge. Chip select is active low and frames exactly 16 serial clock periods.

Top module: `spi_word_tx`

## Requirements
- R1: After reset, the register reads 0, `cs_n` is 1, and `sclk` and `mosi` are 0.
- R2: A write stores bits 31:17 and 15:0. These bits read back unchanged until the next write, including across and after a transfer. Bit 16 always reads the busy state.
- R3: A write with bit 17 = 1 and bit 16 = 1 while idle starts a transfer. From the next cycle, `cs_n` is 0 and bit 16 reads 1.
- R4: The 16 bits sampled on the rising edges of `sclk` equal the payload latched at start, MSB first. `mosi` does not change across a rising edge.
- R5: `cs_n` stays low for exactly 16*DIV system cycles. `sclk` has a period of DIV cycles, low for DIV/2 cycles and then high.
- R6: Bit 16 reads 0 in the same cycle that `cs_n` returns high.
- R7: A write with bit 16 = 1 and bit 17 = 0 starts nothing. `cs_n` stays high and bit 16 reads 0.
- R8: A start written during a transfer is ignored. The word in flight is the original payload, and `cs_n` still rises after 16*DIV cycles. The new payload bits are stored for read-back only.
- R9: With no new start write, no further transfer follows a completed one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| rd_data | output | 32 | Register read value: stored fields with live busy in bit 16 |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low chip select |

## Verification
A write is taken at one rising edge. Its effect on `rd_data`, `cs_n` and `mosi` is due at the next edge, so the bench drives on the falling edge and checks at the following falling edge. During a transfer, the bench samples every falling edge. It counts the cycles in which `cs_n` is low, finds rising edges of `sclk` as a 0-to-1 change between neighbouring samples, and takes `mosi` at that sample. It checks busy on the first sample with `cs_n` high, which is the same cycle in which the hardware drops it.

// File: rtl/spi_word_tx.sv
module spi_word_tx #(
  parameter int DIV  = 4,
  parameter int BITS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        sclk,
  output logic        mosi,
  output logic        cs_n
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int BW = $clog2(BITS);
  localparam int LO = DIV / 2;

  logic [31:BITS+1] hi;
  logic [BITS-1:0]  pay, shreg;
  logic             busy;
  logic [CW-1:0]    cnt;
  logic [BW-1:0]    bcnt;

  wire go       = wr_en & wr_data[BITS+1] & wr_data[BITS] & ~busy;
  wire tick_end = busy & (cnt == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi    <= '0;
      pay   <= '0;
      shreg <= '0;
      busy  <= 1'b0;
      cnt   <= '0;
      bcnt  <= '0;
    end else begin
      if (wr_en) begin
        hi  <= wr_data[31:BITS+1];
        pay <= wr_data[BITS-1:0];
      end
      if (go) begin
        busy  <= 1'b1;
        shreg <= wr_data[BITS-1:0];
        cnt   <= '0;
        bcnt  <= '0;
      end else if (busy) begin
        if (tick_end) begin
          cnt <= '0;
          if (bcnt == BW'(BITS - 1)) begin
            busy <= 1'b0;
          end else begin
            bcnt  <= bcnt + 1'b1;
            shreg <= {shreg[BITS-2:0], 1'b0};
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign rd_data = {hi, busy, pay};
  assign sclk    = busy & (cnt >= CW'(LO));
  assign mosi    = busy & shreg[BITS-1];
  assign cs_n    = ~busy;

  // R3
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[BITS+1] && wr_data[BITS] && !busy) |=> (busy && shreg == $past(wr_data[BITS-1:0])));

  // R7
  no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[BITS+1] && !busy) |=> !busy);

  // R8
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(tick_end)) |-> $stable(shreg));

  // R4
  mosi_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(busy)) |-> $stable(mosi));

  // R5
  frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(bcnt) == BW'(BITS - 1) && $past(cnt) == CW'(DIV - 1)));
endmodule

// File: tb/spi_word_tx_tb.sv
module spi_word_tx_tb;
  localparam int DIV = 4;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic sclk, mosi, cs_n;
  int total = 0, bad = 0;

  spi_word_tx #(.DIV(DIV), .BITS(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .sclk(sclk), .mosi(mosi), .cs_n(cs_n));

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge clk); wr_en = 1; wr_data = v;
    @(negedge clk); wr_en = 0;
  endtask

  // starts a transfer of v; optionally writes v2 at sample index inj
  task automatic run(input logic [31:0] v, input int inj, input logic [31:0] v2);
    logic [15:0] got = '0;
    int lows = 0, rises = 0;
    logic psclk = 0, pmosi = 0, mstable = 1;
    wr(v);
    chk("R3 cs_n low after start", {31'b0, cs_n}, 32'd0);
    chk("R3 busy reads 1", {31'b0, rd_data[16]}, 32'd1);
    while (cs_n == 0 && lows < 1000) begin
      lows++;
      if (sclk && !psclk) begin
        got = {got[14:0], mosi};
        rises++;
        if (mosi !== pmosi) mstable = 0;
      end
      if (psclk && sclk == 0 && lows % DIV != 1) mstable = 0;
      psclk = sclk; pmosi = mosi;
      if (lows == inj) begin wr_en = 1; wr_data = v2; end
      else wr_en = 0;
      @(negedge clk);
    end
    wr_en = 0;
    chk("R5 cs_n low cycles", lows, 16 * DIV);
    chk("R4 rising edges", rises, 32'd16);
    chk("R4 R8 word shifted", {16'b0, got}, {16'b0, v[15:0]});
    chk("R4 mosi stable at rise", {31'b0, mstable}, 32'd1);
    chk("R6 busy clear with cs_n high", {31'b0, rd_data[16]}, 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 rd_data", rd_data, 32'd0);
    chk("R1 pins", {29'b0, cs_n, sclk, mosi}, 32'b100);
  endtask

  task automatic t_readback;
    wr(32'hABC2_5A3C);
    chk("R2 readback", rd_data, 32'hABC2_5A3C);
    chk("R2 no start", {31'b0, cs_n}, 32'd1);
  endtask

  task automatic t_transfers;
    run(32'hABC3_A55A, -1, 0);
    chk("R2 fields after transfer", rd_data, 32'hABC2_A55A);
    run(32'h0003_8001, -1, 0);
    run(32'hFFFF_FFFF, -1, 0);
    chk("R2 upper after transfer", rd_data, 32'hFFFE_FFFF);
    run(32'h0003_0000, -1, 0);
  endtask

  task automatic t_disabled;
    wr(32'h0001_1234);
    chk("R7 cs_n stays high", {31'b0, cs_n}, 32'd1);
    chk("R7 bit16 reads 0", rd_data, 32'h0000_1234);
    repeat (8) @(negedge clk);
    chk("R7 still idle", {31'b0, cs_n}, 32'd1);
  endtask

  task automatic t_busy_start;
    run(32'h0003_C3F0, 10, 32'h0003_1111);
    chk("R8 new payload stored", rd_data, 32'h0002_1111);
    repeat (3) @(negedge clk);
    chk("R8 no second frame", {31'b0, cs_n}, 32'd1);
  endtask

  task automatic t_no_restart;
    int lowseen = 0;
    run(32'h0003_0F0F, -1, 0);
    for (int i = 0; i < 40 * DIV; i++) begin
      @(negedge clk);
      if (!cs_n) lowseen++;
    end
    chk("R9 no new transfer", lowseen, 32'd0);
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_readback;
    t_transfers;
    t_disabled;
    t_busy_start;
    t_no_restart;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule